// File: doc/BRIEF.md
# SPI Host Register and FIFO Controller

This block is the software-facing front end of an SPI host. A simple 32-bit register bus (write strobe, read strobe, byte address, data) reaches a small register map. That map holds clock, delay, frame-format and flash-control settings as plain storage. It also holds chip-select controls, two FIFO watermarks and an interrupt enable mask. Bytes written to the transmit data register enter an 8-deep transmit FIFO. The block hands them one at a time to an external byte-exchange shifter through a start/busy/done handshake. Each byte returned by the shifter is pushed into an 8-deep receive FIFO, unless the frame format selects transmit-only.

Software reads the receive data register to pop bytes. Bit 31 of the transmit and receive data registers reports full and empty. Two watermark comparisons give level-sensitive pending bits, and the enable mask folds these into a single interrupt line. The controller checks writes to the select and watermark registers and drops values that are out of range. Per-slave select outputs follow the chosen slave, the select mode and the per-slave idle levels.

Top module: `spi_host_regfifo`

## Requirements
- R1: After reset, the registers read as follows. Clock divider (0x00) reads 0x3, delay0 (0x28) reads 0x1001, delay1 (0x2C) reads 0x1, and select default (0x14) has one bit set for each implemented select. Receive data (0x4C) reads 0x80000000. All other registers read 0, the interrupt is low, and each select output sits at its select-default bit.
- R2: A write to transmit data (0x48) pushes bits 7:0 into the transmit FIFO when it holds fewer than 8 bytes. A write made while it holds 8 bytes is dropped.
- R3: A read of transmit data (0x48) returns 0x80000000 when the transmit FIFO holds 8 bytes and 0 otherwise.
- R4: A read of receive data (0x4C) returns 0x80000000 when the receive FIFO is empty. Otherwise it returns the oldest byte in bits 7:0 with bit 31 clear, and removes that byte.
- R5: Pending bit 0 (register 0x74) is 1 exactly while the transmit FIFO count is strictly below the TX watermark (0x50).
- R6: Pending bit 1 (register 0x74) is 1 exactly while the receive FIFO count is strictly above the RX watermark (0x54).
- R7: The interrupt output is high exactly when some pending bit is set together with the same bit of the enable register (0x70, bits 1:0).
- R8: The block ignores the following writes: a watermark write of 8 or more, a select-mode (0x18) write above 3, a select-id (0x10) write not below the number of selects, and a select-default write not below 2^(number of selects).
- R9: With frame-format (0x40) bit 3 set, returned bytes are discarded. With it clear, a returned byte is pushed only when the receive FIFO holds fewer than 8 bytes, and later bytes are dropped.
- R10: Writes to the pending register and to receive data change nothing. Reads of unmapped offsets return 0, and writes to them are ignored.
- R11: The block asserts xfer_start for one cycle with the oldest transmit byte, and only when no exchange is outstanding, xfer_busy is low and the transmit FIFO is not empty. The byte is removed from the FIFO in that cycle. The exchange remains outstanding until xfer_done.
- R12: Select output i equals select-default bit i, inverted while select i is active. Select i is active only when the select id equals i. Mode 2 makes it active at all times, mode 3 never, and modes 0 and 1 only while an exchange is outstanding.
- R13: The clock divider, clock mode, delay0, delay1, frame format, both flash registers and the enable register store any 32-bit write and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data) |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| irq | output | 1 | Level interrupt |
| xfer_start | output | 1 | One-cycle request to exchange xfer_txbyte |
| xfer_txbyte | output | 8 | Byte to transmit |
| xfer_busy | input | 1 | Shifter cannot accept a byte |
| xfer_done | input | 1 | Exchange finished, xfer_rxbyte valid |
| xfer_rxbyte | input | 8 | Byte received by the shifter |
| sel_n | output | NUM_SEL | Per-slave select lines |

## Verification
The hardest conditions to reach are the FIFO edges. These are a transmit write that arrives while the FIFO holds 8 bytes, and a returned byte that arrives while the receive FIFO is full. Both are hard to reach because the shifter normally drains transmit data as soon as it arrives. The bench therefore holds the modelled shifter's busy line high while it writes nine bytes, reads the full flag, and then releases the shifter. Later it streams ten bytes with no reads, so the last two returned bytes reach a full receive FIFO. A behavioural queue model runs alongside and is compared on every cycle, including cycles in which a pop and a push land together.

// File: rtl/spi_host_regfifo.sv
module spi_host_regfifo #(
  parameter int NUM_SEL = 2,
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              xfer_start,
  output logic [7:0]        xfer_txbyte,
  input  logic              xfer_busy,
  input  logic              xfer_done,
  input  logic [7:0]        xfer_rxbyte,
  output logic [NUM_SEL-1:0] sel_n
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_SCKM = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_SID  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_SDEF = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_SMOD = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_DLY0 = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_DLY1 = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_FMT  = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(8'h48);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(8'h4C);
  localparam logic [ADDR_W-1:0] A_TXM  = ADDR_W'(8'h50);
  localparam logic [ADDR_W-1:0] A_RXM  = ADDR_W'(8'h54);
  localparam logic [ADDR_W-1:0] A_FCTL = ADDR_W'(8'h60);
  localparam logic [ADDR_W-1:0] A_FFMT = ADDR_W'(8'h64);
  localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(8'h70);
  localparam logic [ADDR_W-1:0] A_IP   = ADDR_W'(8'h74);
  localparam logic [31:0] SDEF_RST = 32'((64'd1 << NUM_SEL) - 64'd1);

  logic [31:0] r_div, r_sckm, r_sid, r_sdef, r_smod, r_dly0, r_dly1, r_fmt;
  logic [31:0] r_txm, r_rxm, r_fctl, r_ffmt, r_ie;
  logic        in_flight;

  logic [7:0]       tx_mem [DEPTH];
  logic [7:0]       rx_mem [DEPTH];
  logic [PTR_W-1:0] tx_rp, tx_wp, rx_rp, rx_wp;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;

  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_push, tx_pop, rx_push, rx_pop;
  logic [1:0] pend;

  function automatic logic wr_at(input logic [ADDR_W-1:0] a);
    return bus_wr && (bus_addr == a);
  endfunction

  assign tx_full  = (tx_cnt == CNT_W'(DEPTH));
  assign tx_empty = (tx_cnt == '0);
  assign rx_full  = (rx_cnt == CNT_W'(DEPTH));
  assign rx_empty = (rx_cnt == '0);

  assign xfer_start  = !in_flight && !xfer_busy && !tx_empty;
  assign xfer_txbyte = tx_mem[tx_rp];

  assign tx_push = wr_at(A_TXD) && !tx_full;
  assign tx_pop  = xfer_start;
  assign rx_push = xfer_done && !r_fmt[3] && !rx_full;
  assign rx_pop  = bus_rd && (bus_addr == A_RXD) && !rx_empty;

  assign pend[0] = 32'(tx_cnt) < r_txm;
  assign pend[1] = 32'(rx_cnt) > r_rxm;
  assign irq     = |(pend & r_ie[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_div  <= 32'h3;
      r_sckm <= '0;
      r_sid  <= '0;
      r_sdef <= SDEF_RST;
      r_smod <= '0;
      r_dly0 <= 32'h1001;
      r_dly1 <= 32'h1;
      r_fmt  <= '0;
      r_txm  <= '0;
      r_rxm  <= '0;
      r_fctl <= '0;
      r_ffmt <= '0;
      r_ie   <= '0;
    end else begin
      if (wr_at(A_DIV))  r_div  <= bus_wdata;
      if (wr_at(A_SCKM)) r_sckm <= bus_wdata;
      if (wr_at(A_DLY0)) r_dly0 <= bus_wdata;
      if (wr_at(A_DLY1)) r_dly1 <= bus_wdata;
      if (wr_at(A_FMT))  r_fmt  <= bus_wdata;
      if (wr_at(A_FCTL)) r_fctl <= bus_wdata;
      if (wr_at(A_FFMT)) r_ffmt <= bus_wdata;
      if (wr_at(A_IE))   r_ie   <= bus_wdata;
      if (wr_at(A_SID)  && bus_wdata < 32'(NUM_SEL)) r_sid <= bus_wdata;
      if (wr_at(A_SDEF) && {1'b0, bus_wdata} < (33'd1 << NUM_SEL)) r_sdef <= bus_wdata;
      if (wr_at(A_SMOD) && bus_wdata <= 32'd3) r_smod <= bus_wdata;
      if (wr_at(A_TXM)  && bus_wdata < 32'(DEPTH)) r_txm <= bus_wdata;
      if (wr_at(A_RXM)  && bus_wdata < 32'(DEPTH)) r_rxm <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
      in_flight <= 1'b0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + PTR_W'(1);
      if (tx_pop)  tx_rp <= tx_rp + PTR_W'(1);
      tx_cnt <= tx_cnt + CNT_W'(tx_push) - CNT_W'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + PTR_W'(1);
      if (rx_pop)  rx_rp <= rx_rp + PTR_W'(1);
      rx_cnt <= rx_cnt + CNT_W'(rx_push) - CNT_W'(rx_pop);
      if (xfer_start)     in_flight <= 1'b1;
      else if (xfer_done) in_flight <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= xfer_rxbyte;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DIV:  bus_rdata = r_div;
      A_SCKM: bus_rdata = r_sckm;
      A_SID:  bus_rdata = r_sid;
      A_SDEF: bus_rdata = r_sdef;
      A_SMOD: bus_rdata = r_smod;
      A_DLY0: bus_rdata = r_dly0;
      A_DLY1: bus_rdata = r_dly1;
      A_FMT:  bus_rdata = r_fmt;
      A_TXD:  bus_rdata = {tx_full, 31'b0};
      A_RXD:  bus_rdata = rx_empty ? 32'h8000_0000 : {24'b0, rx_mem[rx_rp]};
      A_TXM:  bus_rdata = r_txm;
      A_RXM:  bus_rdata = r_rxm;
      A_FCTL: bus_rdata = r_fctl;
      A_FFMT: bus_rdata = r_ffmt;
      A_IE:   bus_rdata = r_ie;
      A_IP:   bus_rdata = {30'b0, pend};
      default: bus_rdata = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    assign sel_n[g] = r_sdef[g] ^ ((r_sid == 32'(g)) &&
                      (r_smod == 32'd2 || (r_smod != 32'd3 && in_flight)));
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CNT_W'(DEPTH) && rx_cnt <= CNT_W'(DEPTH));
  p_start_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  p_start_pops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !(bus_wr && bus_addr == A_TXD)) |=> tx_cnt == $past(tx_cnt) - CNT_W'(1));
  p_dir_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && r_fmt[3] && !bus_rd) |=> $stable(rx_cnt));
  p_mark_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TXM && bus_wdata >= 32'(DEPTH)) |=> $stable(r_txm));
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (r_ie[1:0] == 2'b00) |-> !irq);
  p_rxd_readonly_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_RXD && !bus_rd && !xfer_done) |=> $stable(rx_cnt));
endmodule

// File: tb/sim_spi_host_regfifo.sv
module sim_spi_host_regfifo;
  localparam int NSEL = 2;
  localparam int DEP  = 8;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, xfer_start, xfer_busy = 0, xfer_done = 0;
  logic [7:0] xfer_txbyte, xfer_rxbyte = '0;
  logic [NSEL-1:0] sel_n;

  always #4 clk = ~clk;

  spi_host_regfifo #(.NUM_SEL(NSEL), .DEPTH(DEP), .ADDR_W(7)) u0 (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata, .irq,
    .xfer_start, .xfer_txbyte, .xfer_busy, .xfer_done, .xfer_rxbyte, .sel_n);

  int checks = 0, fails = 0;
  logic [31:0] m_div = 3, m_sckm = 0, m_sid = 0, m_sdef = 3, m_smod = 0, m_dly0 = 32'h1001;
  logic [31:0] m_dly1 = 1, m_fmt = 0, m_txm = 0, m_rxm = 0, m_fctl = 0, m_ffmt = 0, m_ie = 0;
  logic m_busy = 0;
  logic [7:0] txq[$], rxq[$];
  int sh_cnt = 0, lat = 2;
  logic [7:0] sh_byte = 0;
  logic stall = 0;
  logic [31:0] last_rd;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] m_rdata(logic [6:0] a);
    case (a)
      7'h00: return m_div;   7'h04: return m_sckm; 7'h10: return m_sid;
      7'h14: return m_sdef;  7'h18: return m_smod; 7'h28: return m_dly0;
      7'h2C: return m_dly1;  7'h40: return m_fmt;  7'h50: return m_txm;
      7'h54: return m_rxm;   7'h60: return m_fctl; 7'h64: return m_ffmt;
      7'h70: return m_ie;
      7'h48: return (txq.size() == DEP) ? 32'h8000_0000 : 32'h0;
      7'h4C: return (rxq.size() == 0) ? 32'h8000_0000 : {24'h0, rxq[0]};
      7'h74: return {30'h0, rxq.size() > int'(m_rxm), txq.size() < int'(m_txm)};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag(logic [6:0] a);
    case (a)
      7'h48: return "R3 txdata";
      7'h4C: return "R4 rxdata";
      7'h74: return "R5 R6 pending";
      7'h10, 7'h14, 7'h18, 7'h50, 7'h54: return "R8 guarded reg";
      7'h00, 7'h04, 7'h28, 7'h2C, 7'h40, 7'h60, 7'h64, 7'h70: return "R13 config reg";
      default: return "R10 reserved";
    endcase
  endfunction

  function automatic logic m_irq();
    logic [31:0] p = m_rdata(7'h74);
    return |(p[1:0] & m_ie[1:0]);
  endfunction

  function automatic logic [NSEL-1:0] m_sel();
    logic [NSEL-1:0] s;
    for (int i = 0; i < NSEL; i++)
      s[i] = m_sdef[i] ^ ((m_sid == i) && (m_smod == 2 || (m_smod != 3 && m_busy)));
    return s;
  endfunction

  task automatic cyc(logic wr, logic rd, logic [6:0] a, logic [31:0] d);
    logic st;
    logic [7:0] b;
    @(negedge clk);
    chk(rtag(bus_addr), bus_rdata, m_rdata(bus_addr));
    chk("R7 irq", {31'h0, irq}, {31'h0, m_irq()});
    st = !m_busy && !xfer_busy && txq.size() != 0;
    chk("R11 start", {31'h0, xfer_start}, {31'h0, st});
    if (st) chk("R11 txbyte", {24'h0, xfer_txbyte}, {24'h0, txq[0]});
    chk("R12 select", 32'(sel_n), 32'(m_sel()));
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    xfer_done = 0; xfer_busy = stall;
    if (sh_cnt > 1) begin xfer_busy = 1; sh_cnt--; end
    else if (sh_cnt == 1) begin xfer_done = 1; xfer_rxbyte = sh_byte; sh_cnt = 0; end
    #1;
    last_rd = bus_rdata;
    st = !m_busy && !xfer_busy && txq.size() != 0;
    b = st ? txq[0] : 8'h0;
    if (st) void'(txq.pop_front());
    if (wr && a == 7'h48 && txq.size() + (st ? 1 : 0) < DEP) txq.push_back(d[7:0]);
    if (xfer_done && !m_fmt[3] && rxq.size() < DEP) begin
      if (rd && a == 7'h4C) void'(rxq.pop_front());
      rxq.push_back(xfer_rxbyte);
    end else if (rd && a == 7'h4C && rxq.size() != 0) void'(rxq.pop_front());
    if (st) m_busy = 1; else if (xfer_done) m_busy = 0;
    if (st) begin sh_cnt = lat; sh_byte = b ^ 8'hA5; end
    if (wr) case (a)
      7'h00: m_div = d;  7'h04: m_sckm = d; 7'h28: m_dly0 = d; 7'h2C: m_dly1 = d;
      7'h40: m_fmt = d;  7'h60: m_fctl = d; 7'h64: m_ffmt = d; 7'h70: m_ie = d;
      7'h10: if (d < NSEL) m_sid = d;
      7'h14: if ({1'b0, d} < (33'd1 << NSEL)) m_sdef = d;
      7'h18: if (d <= 3) m_smod = d;
      7'h50: if (d < DEP) m_txm = d;
      7'h54: if (d < DEP) m_rxm = d;
      default: ;
    endcase
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d); cyc(1, 0, a, d); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 0, 7'h00, 0); endtask
  task automatic rdchk(logic [6:0] a, logic [31:0] exp, string tag);
    cyc(0, 1, a, 0);
    chk(tag, last_rd, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset values
    rdchk(7'h00, 32'h3, "R1 divider");
    rdchk(7'h28, 32'h1001, "R1 delay0");
    rdchk(7'h2C, 32'h1, "R1 delay1");
    rdchk(7'h14, 32'h3, "R1 select default");
    rdchk(7'h4C, 32'h8000_0000, "R1 rx empty");
    rdchk(7'h74, 32'h0, "R1 pending");
    rdchk(7'h10, 32'h0, "R1 select id");
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 sel_n", 32'(sel_n), 32'h3);
    // R13 plain storage
    wr(7'h00, 32'hDEAD_0055); rdchk(7'h00, 32'hDEAD_0055, "R13 divider");
    wr(7'h64, 32'h1234_5678); rdchk(7'h64, 32'h1234_5678, "R13 flash format");
    // R8 guarded writes
    wr(7'h50, 8);  rdchk(7'h50, 0, "R8 txmark 8 ignored");
    wr(7'h50, 4);  rdchk(7'h50, 4, "R8 txmark 4 taken");
    wr(7'h18, 4);  rdchk(7'h18, 0, "R8 mode 4 ignored");
    wr(7'h10, 2);  rdchk(7'h10, 0, "R8 id 2 ignored");
    wr(7'h14, 4);  rdchk(7'h14, 3, "R8 default 4 ignored");
    wr(7'h54, 9);  rdchk(7'h54, 0, "R8 rxmark 9 ignored");
    // R10 read-only and reserved
    wr(7'h08, 32'hFFFF_FFFF); rdchk(7'h08, 0, "R10 reserved read");
    rdchk(7'h00, 32'hDEAD_0055, "R10 reserved write no effect");
    wr(7'h74, 32'hFFFF_FFFF); rdchk(7'h74, 32'h1, "R10 pending read-only");
    wr(7'h4C, 32'h0000_0011); rdchk(7'h4C, 32'h8000_0000, "R10 rxdata read-only");
    rdchk(7'h7C, 0, "R10 unmapped");
    // R5 R7 tx watermark interrupt
    wr(7'h70, 1); idle(1);
    chk("R7 irq tx watermark", {31'h0, irq}, 32'h1);
    // R2 R3 fill with shifter stalled
    stall = 1;
    wr(7'h54, 3);
    for (int i = 0; i < 9; i++) wr(7'h48, 32'hF00 + i);
    rdchk(7'h48, 32'h8000_0000, "R3 tx full flag");
    rdchk(7'h74, 32'h0, "R5 tx count above mark");
    stall = 0;
    idle(40);
    rdchk(7'h48, 32'h0, "R3 tx not full");
    wr(7'h70, 2); idle(1);
    chk("R6 irq rx above mark", {31'h0, irq}, 32'h1);
    for (int i = 0; i < 8; i++) rdchk(7'h4C, {24'h0, 8'(i) ^ 8'hA5}, "R4 R11 rx order");
    rdchk(7'h4C, 32'h8000_0000, "R2 ninth byte dropped");
    // R9 transmit-only
    lat = 1;
    wr(7'h40, 8); wr(7'h48, 7); wr(7'h48, 9); idle(10);
    rdchk(7'h4C, 32'h8000_0000, "R9 discard when direction set");
    // R9 rx full drop
    wr(7'h40, 0);
    for (int i = 0; i < 10; i++) wr(7'h48, 32'h30 + i);
    idle(30);
    for (int i = 0; i < 8; i++) rdchk(7'h4C, {24'h0, 8'(8'h30 + i) ^ 8'hA5}, "R9 rx keeps first");
    rdchk(7'h4C, 32'h8000_0000, "R9 overflow dropped");
    // R12 selects
    wr(7'h10, 1); wr(7'h18, 2); idle(1);
    chk("R12 hold mode", 32'(sel_n), 32'h1);
    wr(7'h18, 3); idle(1);
    chk("R12 off mode", 32'(sel_n), 32'h3);
    wr(7'h14, 1); wr(7'h18, 0); lat = 4; wr(7'h48, 5); idle(2);
    chk("R12 auto active", 32'(sel_n), 32'h3);
    idle(10);
    chk("R12 auto idle", 32'(sel_n), 32'h1);
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got=%h exp=%h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule